// File: doc/BRIEF.md
# Maximal-Length Noise Source with Period Sync

This block produces a pseudo-random bit stream that serves as a broadband test signal for audio equipment. Its core is a shift register with XOR feedback, moved forward by a sample-rate tick. The register state cycles through every nonzero value before it repeats. The most significant bit goes out as the noise bit. The full register is also available for wider use, for example as a multi-bit dither word.

Once per period the register reaches the state in which every bit is one. On the step that enters that state, the block emits a one-cycle sync pulse. A converter or capture engine can start on this pulse, so repeated acquisitions line up with the stimulus sample for sample. Responses can then be averaged, and a transfer function can be formed by comparing the input with the output.

A synchronous reset returns the register to the all-ones seed. A load strobe can place any chosen value into the register. If the register ever holds all zeros, it is put back to the seed on the next step.

Top module: `prbs_sync_source`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register is set to all ones and `sync_trig` is driven low after that edge.
- R2: On an edge where `step_en` is high (and `rst` and `seed_load` are low), the register shifts one place toward the MSB. Bit 0 takes the XOR of the bits selected by `TAPS`. With the default `TAPS` of 16'hD008, these are bits 15, 14, 12 and 3, which gives x^16 + x^15 + x^13 + x^4 + 1.
- R3: On an edge where `step_en`, `seed_load` and `rst` are all low, the register keeps its value.
- R4: When `seed_load` is high, `seed_val` is copied into the register regardless of `step_en`. `rst` takes priority over `seed_load`.
- R5: If the register holds all zeros, the next enabled step loads all ones instead of shifting. An enabled step never leaves the register at zero.
- R6: Starting from all ones with a step on every tick, the all-ones state returns after exactly 2^W − 1 steps and not before. With the default width this is 65,535 steps.
- R7: `sync_trig` goes high for exactly one cycle: the first cycle in which the register shows all ones after an enabled step, recovery steps included. Entering all ones through reset or `seed_load` gives no pulse.
- R8: When `trig_en` is low on the step that enters all ones, no pulse is produced. The register still advances as normal.
- R9: `noise_out` always equals bit W−1 of `lfsr_state`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to the all-ones seed |
| step_en | input | 1 | Sample-rate tick; advances the register by one step |
| seed_load | input | 1 | Loads `seed_val` into the register |
| seed_val | input | W | Value to load |
| trig_en | input | 1 | Allows the sync pulse |
| noise_out | output | 1 | Serial noise bit (register MSB) |
| lfsr_state | output | W | Current register contents |
| sync_trig | output | 1 | One-cycle pulse on entry into the all-ones state |

## Verification
The bench builds the block twice. The first copy uses the default width of 16 with taps 16'hD008. It is walked through one complete 65,535-step period, so the exact return to all ones and the single pulse per period are observed directly. The second copy uses W = 5 with taps 5'h14 (x^5 + x^3 + 1). Two full 31-step periods fit in a few dozen cycles, which shows that the period follows the width parameter and that the pulse spacing repeats. The wide copy also receives loads of zero and of the state just before all ones (16'h7FFF), to reach the recovery path and the trigger gate.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

  // Action selected for the shift register on the coming edge
  typedef enum logic [2:0] {
    ACT_HOLD    = 3'd0,
    ACT_RESET   = 3'd1,
    ACT_LOAD    = 3'd2,
    ACT_SHIFT   = 3'd3,
    ACT_RECOVER = 3'd4
  } lfsr_act_e;

  // True for actions that count as a generator step
  function automatic logic is_advance(input lfsr_act_e a);
    return (a == ACT_SHIFT) || (a == ACT_RECOVER);
  endfunction

endpackage

// File: rtl/prbs_step_ctrl.sv
module prbs_step_ctrl
  import prbs_pkg::*;
(
  input  logic      rst,
  input  logic      seed_load,
  input  logic      step_en,
  input  logic      is_zero,
  output lfsr_act_e act
);

  // Priority: reset, then load, then step (recover from zero if needed)
  always_comb begin
    if (rst)            act = ACT_RESET;
    else if (seed_load) act = ACT_LOAD;
    else if (step_en)   act = is_zero ? ACT_RECOVER : ACT_SHIFT;
    else                act = ACT_HOLD;
  end

endmodule

// File: rtl/prbs_lfsr_core.sv
module prbs_lfsr_core
  import prbs_pkg::*;
#(
  parameter int           W    = 16,
  parameter logic [W-1:0] TAPS = 16'hD008
) (
  input  logic         clk,
  input  logic         rst,
  input  lfsr_act_e    act,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] state_q,
  output logic [W-1:0] nxt,
  output logic         is_zero
);

  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] tapped;
  logic         fb;

  // Each tap position contributes its bit to the feedback XOR
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_tap
      if (TAPS[gi]) begin : g_on
        assign tapped[gi] = state_q[gi];
      end else begin : g_off
        assign tapped[gi] = 1'b0;
      end
    end
  endgenerate

  assign fb      = ^tapped;
  assign is_zero = (state_q == '0);

  always_comb begin
    case (act)
      ACT_RESET:   nxt = ALL_ONES;
      ACT_LOAD:    nxt = load_val;
      ACT_SHIFT:   nxt = {state_q[W-2:0], fb};
      ACT_RECOVER: nxt = ALL_ONES;
      default:     nxt = state_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ALL_ONES;
    else     state_q <= nxt;
  end

  // R3: an idle edge leaves the register untouched
  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_HOLD) |=> $stable(state_q));

  // R5: a recovery step lands on the seed
  a_r5_recover_to_ones: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_RECOVER) |=> (state_q == ALL_ONES));

endmodule

// File: rtl/prbs_ones_trigger.sv
module prbs_ones_trigger
  import prbs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  lfsr_act_e    act,
  input  logic         trig_en,
  input  logic [W-1:0] nxt,
  output logic         trig_q
);

  logic hit;

  // Pulse only when a real step is about to produce all ones
  assign hit = is_advance(act) && trig_en && (&nxt);

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= hit;
  end

  // R7: the pulse never lasts two cycles
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst)
    trig_q |=> !trig_q);

  // R8: a disabled trigger produces nothing
  a_r8_gate_blocks: assert property (@(posedge clk) disable iff (rst)
    !trig_en |=> !trig_q);

endmodule

// File: rtl/prbs_sync_source.sv
module prbs_sync_source
  import prbs_pkg::*;
#(
  parameter int           W    = 16,
  parameter logic [W-1:0] TAPS = 16'hD008
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_en,
  input  logic         seed_load,
  input  logic [W-1:0] seed_val,
  input  logic         trig_en,
  output logic         noise_out,
  output logic [W-1:0] lfsr_state,
  output logic         sync_trig
);

  lfsr_act_e    act;
  logic [W-1:0] nxt;
  logic         is_zero;

  prbs_step_ctrl u_ctrl (
    .rst       (rst),
    .seed_load (seed_load),
    .step_en   (step_en),
    .is_zero   (is_zero),
    .act       (act)
  );

  prbs_lfsr_core #(.W(W), .TAPS(TAPS)) u_core (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .load_val (seed_val),
    .state_q  (lfsr_state),
    .nxt      (nxt),
    .is_zero  (is_zero)
  );

  prbs_ones_trigger #(.W(W)) u_trig (
    .clk     (clk),
    .rst     (rst),
    .act     (act),
    .trig_en (trig_en),
    .nxt     (nxt),
    .trig_q  (sync_trig)
  );

  assign noise_out = lfsr_state[W-1];

  // R1: reset seeds all ones and silences the trigger
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> ((&lfsr_state) && !sync_trig));

  // R2: a normal step moves every bit one place up
  a_r2_shift_up: assert property (@(posedge clk) disable iff (rst)
    (step_en && !seed_load && (lfsr_state != '0)) |=>
      (lfsr_state[W-1:1] == $past(lfsr_state[W-2:0])));

  // R4: load strobe takes the offered value
  a_r4_seed_load: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> (lfsr_state == $past(seed_val)));

  // R5: a step never leaves the register empty
  a_r5_no_zero_after_step: assert property (@(posedge clk) disable iff (rst)
    (step_en && !seed_load) |=> (lfsr_state != '0));

  // R7: pulse coincides with all ones in the register
  a_r7_trig_at_ones: assert property (@(posedge clk) disable iff (rst)
    sync_trig |-> (&lfsr_state));

endmodule

// File: tb/prbs_sync_source_tb_top.sv
module prbs_sync_source_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam logic [W-1:0] TAPS = 16'hD008;
  localparam logic [W-1:0] ONES = '1;
  localparam int PERIOD = (1 << W) - 1;
  localparam int WS = 5;
  localparam logic [WS-1:0] TAPS_S = 5'h14;
  localparam int PERIOD_S = (1 << WS) - 1;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         rst = 1'b1, step_en = 1'b0, seed_load = 1'b0, trig_en = 1'b0;
  logic [W-1:0] seed_val = '0;
  logic         noise_out, sync_trig;
  logic [W-1:0] lfsr_state;

  logic          rst_s = 1'b1, en_s = 1'b0;
  logic          noise_s, trig_s;
  logic [WS-1:0] state_s;

  prbs_sync_source #(.W(W), .TAPS(TAPS)) dut_i (
    .clk(clk), .rst(rst), .step_en(step_en), .seed_load(seed_load),
    .seed_val(seed_val), .trig_en(trig_en), .noise_out(noise_out),
    .lfsr_state(lfsr_state), .sync_trig(sync_trig));

  prbs_sync_source #(.W(WS), .TAPS(TAPS_S)) dut_small_i (
    .clk(clk), .rst(rst_s), .step_en(en_s), .seed_load(1'b0),
    .seed_val('0), .trig_en(1'b1), .noise_out(noise_s),
    .lfsr_state(state_s), .sync_trig(trig_s));

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    logic [W-1:0] st;
    logic         tr;
    string        tag;
  } exp_t;

  exp_t         q[$];
  logic [W-1:0] model = ONES;

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Driver: apply one cycle of inputs and push the expected result
  task automatic drive(input logic r, input logic ld, input logic [W-1:0] sv,
                       input logic en, input logic ten, input string tag);
    exp_t         e;
    logic [W-1:0] nx;
    logic         adv;
    rst = r; seed_load = ld; seed_val = sv; step_en = en; trig_en = ten;
    @(posedge clk);
    #1;
    adv = 1'b0;
    if (r)        nx = ONES;
    else if (ld)  nx = sv;
    else if (en) begin
      adv = 1'b1;
      nx  = (model == '0) ? ONES : {model[W-2:0], ^(model & TAPS)};
    end else      nx = model;
    e.st  = nx;
    e.tr  = adv && ten && (nx == ONES);
    e.tag = tag;
    model = nx;
    q.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compare design outputs at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(lfsr_state == e.st, e.tag, "state", lfsr_state, e.st);
      check(sync_trig == e.tr, e.tag, "trigger", {{(W-1){1'b0}}, sync_trig},
            {{(W-1){1'b0}}, e.tr});
      check(noise_out == lfsr_state[W-1], "R9", "noise bit",
            {{(W-1){1'b0}}, noise_out}, {{(W-1){1'b0}}, lfsr_state[W-1]});
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    int trig_count;
    int trig_at;
    int first_s;
    int second_s;
    int count_s;
    @(negedge clk);
    // R1: reset state
    drive(1, 0, '0, 0, 1, "R1");
    drive(1, 1, 16'h1234, 1, 1, "R1");
    // R2 + R6: one full period from all ones
    trig_count = 0;
    trig_at    = 0;
    for (int i = 1; i <= PERIOD; i++) begin
      drive(0, 0, '0, 1, 1, "R2");
      if (sync_trig) begin
        trig_count++;
        trig_at = i;
      end
    end
    check(trig_count == 1, "R6", "pulses per period", W'(trig_count), W'(1));
    check(trig_at == PERIOD, "R6", "period length", W'(trig_at), W'(PERIOD));
    // R3: hold with tick low, then tick every third cycle
    for (int i = 0; i < 5; i++) drive(0, 0, '0, 0, 1, "R3");
    for (int i = 0; i < 30; i++) begin
      drive(0, 0, '0, 1, 1, "R3");
      drive(0, 0, '0, 0, 1, "R3");
      drive(0, 0, '0, 0, 1, "R3");
    end
    // R4: load wins over step, reset wins over load
    drive(0, 1, 16'h1234, 1, 1, "R4");
    drive(0, 0, '0, 1, 1, "R4");
    drive(1, 1, 16'hABCD, 1, 1, "R4");
    drive(0, 0, '0, 1, 1, "R4");
    // R5: zero state recovers on next step (with pulse)
    drive(0, 1, '0, 0, 1, "R5");
    drive(0, 0, '0, 0, 1, "R5");
    drive(0, 0, '0, 1, 1, "R5");
    drive(0, 0, '0, 1, 1, "R5");
    // R8: recovery with trigger disabled
    drive(0, 1, '0, 0, 0, "R8");
    drive(0, 0, '0, 1, 0, "R8");
    // R8: normal entry into all ones with trigger disabled
    drive(0, 1, 16'h7FFF, 0, 0, "R8");
    drive(0, 0, '0, 1, 0, "R8");
    // R7: normal entry with trigger enabled, then pulse drops
    drive(0, 1, 16'h7FFF, 0, 1, "R7");
    drive(0, 0, '0, 1, 1, "R7");
    drive(0, 0, '0, 0, 1, "R7");
    // R7: loading all ones gives no pulse
    drive(0, 1, ONES, 1, 1, "R7");
    drive(0, 0, '0, 0, 1, "R7");
    drive(0, 0, '0, 0, 0, "R3");
    @(negedge clk);

    // R6: narrow build, two periods
    rst_s = 1'b1;
    repeat (2) @(negedge clk);
    check(state_s == '1, "R1", "small reset state", W'(state_s), W'(5'h1F));
    rst_s = 1'b0;
    en_s  = 1'b1;
    first_s  = 0;
    second_s = 0;
    count_s  = 0;
    for (int i = 1; i <= 2 * PERIOD_S; i++) begin
      @(negedge clk);
      if (trig_s) begin
        count_s++;
        if (first_s == 0) first_s = i;
        else              second_s = i;
      end
    end
    en_s = 1'b0;
    check(count_s == 2, "R6", "small pulse count", W'(count_s), W'(2));
    check(first_s == PERIOD_S, "R6", "small first pulse", W'(first_s), W'(PERIOD_S));
    check(second_s - first_s == PERIOD_S, "R6", "small pulse spacing",
          W'(second_s - first_s), W'(PERIOD_S));
    @(negedge clk);
    finish_run();
  end

endmodule